// File: doc/BRIEF.md
# Character Port Register Block

This block gives a processor a simple byte-oriented serial port through two 32-bit registers on a small register bus. Characters arriving from the link enter a receive queue through a valid/ready stream; software takes them one at a time by reading the data register. Characters written to the data register enter a transmit queue and leave, in the order written, on a second valid/ready stream toward the link.

The data register sits at offset 0x0 and the control register at offset 0x4. A data read pops one character and reports, in the same word, whether a character was actually delivered and how many remain. The control word combines the two interrupt enables, the two pending conditions, a flag that records transmit activity and the current free space in the transmit queue. One interrupt line is raised when an enabled condition is pending.

Stream rules: a beat moves on a rising clock edge where valid and ready are both high. The receive side drops `rx_ready` while its queue is full, and the sender must hold the beat until it is taken. The transmit side keeps `tx_valid` high and `tx_data` unchanged until `tx_ready` takes the beat.

Top module: `char_port_regs`

## Requirements
- R1: After reset `rx_ready` is 1, `tx_valid` is 0, `irq` is 0 and `bus_rvalid` is 0; both queues are empty and both enables are clear.
- R2: A read at offset 0x0 with a non-empty receive queue returns, one cycle later with `bus_rvalid` high, the oldest character in bits [7:0], bit 15 set, and in bits [31:16] the number of characters left after this one; the character is removed.
- R3: A read at offset 0x0 with an empty receive queue returns bit 15 clear, bits [31:16] zero and bits [7:0] zero, and leaves the queue unchanged.
- R4: A write at offset 0x0 places bits [7:0] of the write data in the transmit queue; characters leave on the transmit stream in the order written.
- R5: A write at offset 0x0 while 64 characters are already queued for transmit is discarded.
- R6: The receive stream accepts a beat when `rx_valid` and `rx_ready` are high; `rx_ready` is low while 64 received characters are held, and a beat offered then is not stored.
- R7: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` stays unchanged on the next cycle.
- R8: A read at offset 0x4 returns receive enable at bit 0, transmit enable at bit 1, receive pending at bit 8 (receive queue not empty), transmit pending at bit 9 (at least 32 free transmit slots), the activity flag at bit 10, free transmit slots in bits [31:16], and zero elsewhere.
- R9: `irq` is high exactly when (bit 0 and bit 8) or (bit 1 and bit 9) of the control word are both set, following queue changes one cycle after the handshake or access that caused them.
- R10: A write at offset 0x4 loads the enables from bits 0 and 1; a 1 in bit 10 clears the activity flag, which is set by every completed transmit beat (setting wins over a same-cycle clear).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 3 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the access |
| bus_rvalid | output | 1 | High the cycle after a read access |
| rx_valid | input | 1 | Received character offered |
| rx_ready | output | 1 | Receive queue can take a character |
| rx_data | input | 8 | Received character |
| tx_valid | output | 1 | Character available to transmit |
| tx_ready | input | 1 | Link takes the character |
| tx_data | output | 8 | Character to transmit |
| irq | output | 1 | Interrupt request |

## Verification
Read results land in `bus_rdata` on the clock edge that samples the access, so the bench drives each access after a falling edge and samples the returned word at the next falling edge. Queue levels, `rx_ready`, the pending bits and `irq` change on the edge that completes a handshake or write, so every such check is taken at the falling edge that follows that edge. Transmit beats are checked by a monitor at each falling edge where valid and ready are both high, against a queue of expected characters filled by the write task only for writes the bench expects to be accepted.

// File: rtl/cpr_pkg.sv
package cpr_pkg;
  localparam int unsigned OFS_DATA = 0;
  localparam int unsigned OFS_CTRL = 4;

  localparam int unsigned BIT_RX_EN   = 0;
  localparam int unsigned BIT_TX_EN   = 1;
  localparam int unsigned BIT_RX_PEND = 8;
  localparam int unsigned BIT_TX_PEND = 9;
  localparam int unsigned BIT_ACT     = 10;
  localparam int unsigned BIT_GOOD    = 15;
  localparam int unsigned COUNT_LSB   = 16;

  typedef enum logic [1:0] {
    REG_NONE = 2'd0,
    REG_DATA = 2'd1,
    REG_CTRL = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/cpr_fifo.sv
module cpr_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full,
  output logic [CW-1:0]    level
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr;
  logic [AW-1:0]    rd_ptr;
  logic             do_push;
  logic             do_pop;

  assign empty   = (level == '0);
  assign full    = (level == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + AW'(1);
      if (do_pop)  rd_ptr <= rd_ptr + AW'(1);
      case ({do_push, do_pop})
        2'b10:   level <= level + CW'(1);
        2'b01:   level <= level - CW'(1);
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/cpr_ctrl.sv
module cpr_ctrl import cpr_pkg::*; #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_wr,
  input  logic          wr_rx_en,
  input  logic          wr_tx_en,
  input  logic          wr_act_clr,
  input  logic          tx_beat,
  input  logic [CW-1:0] rx_level,
  input  logic [CW-1:0] tx_level,
  output logic [31:0]   ctrl_word,
  output logic          irq
);
  logic          rx_en;
  logic          tx_en;
  logic          act;
  logic          rx_pend;
  logic          tx_pend;
  logic [CW-1:0] tx_free;

  assign tx_free = CW'(DEPTH) - tx_level;
  assign rx_pend = (rx_level != '0);
  assign tx_pend = (tx_free >= CW'(DEPTH / 2));
  assign irq     = (rx_en && rx_pend) || (tx_en && tx_pend);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_en <= 1'b0;
      tx_en <= 1'b0;
      act   <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        rx_en <= wr_rx_en;
        tx_en <= wr_tx_en;
      end
      if (tx_beat)                   act <= 1'b1;
      else if (ctrl_wr && wr_act_clr) act <= 1'b0;
    end
  end

  always_comb begin
    ctrl_word                       = '0;
    ctrl_word[BIT_RX_EN]            = rx_en;
    ctrl_word[BIT_TX_EN]            = tx_en;
    ctrl_word[BIT_RX_PEND]          = rx_pend;
    ctrl_word[BIT_TX_PEND]          = tx_pend;
    ctrl_word[BIT_ACT]              = act;
    ctrl_word[COUNT_LSB +: CW]      = tx_free;
  end
endmodule

// File: rtl/char_port_regs.sv
module char_port_regs import cpr_pkg::*; #(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 3,
  localparam int unsigned CW = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DATA_W-1:0] rx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_data,
  output logic              irq
);
  reg_sel_e          sel;
  logic              rx_push, rx_pop, rx_empty, rx_full;
  logic [DATA_W-1:0] rx_head;
  logic [CW-1:0]     rx_level;
  logic              tx_push, tx_pop, tx_empty, tx_full;
  logic [CW-1:0]     tx_level;
  logic [31:0]       ctrl_word;
  logic [31:0]       data_word;
  logic              unused_wbits;

  assign unused_wbits = ^{bus_wdata[31:11], bus_wdata[9:DATA_W], tx_full};

  always_comb begin
    sel = REG_NONE;
    if (bus_sel) begin
      if (bus_addr == ADDR_W'(OFS_DATA))      sel = REG_DATA;
      else if (bus_addr == ADDR_W'(OFS_CTRL)) sel = REG_CTRL;
    end
  end

  assign rx_ready = !rx_full;
  assign rx_push  = rx_valid && rx_ready;
  assign rx_pop   = (sel == REG_DATA) && !bus_wr;

  assign tx_valid = !tx_empty;
  assign tx_pop   = tx_valid && tx_ready;
  assign tx_push  = (sel == REG_DATA) && bus_wr;

  cpr_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .push(rx_push), .wdata(rx_data), .pop(rx_pop),
    .head(rx_head), .empty(rx_empty), .full(rx_full), .level(rx_level)
  );

  cpr_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .push(tx_push), .wdata(bus_wdata[DATA_W-1:0]), .pop(tx_pop),
    .head(tx_data), .empty(tx_empty), .full(tx_full), .level(tx_level)
  );

  cpr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .ctrl_wr((sel == REG_CTRL) && bus_wr),
    .wr_rx_en(bus_wdata[BIT_RX_EN]),
    .wr_tx_en(bus_wdata[BIT_TX_EN]),
    .wr_act_clr(bus_wdata[BIT_ACT]),
    .tx_beat(tx_pop),
    .rx_level(rx_level), .tx_level(tx_level),
    .ctrl_word(ctrl_word), .irq(irq)
  );

  always_comb begin
    data_word = '0;
    if (!rx_empty) begin
      data_word[DATA_W-1:0]          = rx_head;
      data_word[BIT_GOOD]            = 1'b1;
      data_word[COUNT_LSB +: CW]     = rx_level - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_sel && !bus_wr;
      if (bus_sel && !bus_wr) begin
        case (sel)
          REG_DATA: bus_rdata <= data_word;
          REG_CTRL: bus_rdata <= ctrl_word;
          default:  bus_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/cpr_checker.sv
module cpr_checker #(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned ADDR_W = 3,
  localparam int unsigned CW = $clog2(DEPTH) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic              bus_rvalid,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [7:0]        tx_data,
  input logic [CW-1:0]     rx_count,
  input logic [CW-1:0]     tx_count
);
  logic data_rd, data_wr;
  assign data_rd = bus_sel && !bus_wr && (bus_addr == '0);
  assign data_wr = bus_sel && bus_wr && (bus_addr == '0);

  assert_read_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr) |=> bus_rvalid);

  assert_pop_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && rx_count != '0) |=>
      (bus_rdata[15] && bus_rdata[31:16] == 16'($past(rx_count)) - 16'd1));

  assert_empty_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && rx_count == '0) |=> (!bus_rdata[15] && bus_rdata[31:16] == 16'd0 && rx_count <= 1));

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && tx_count == CW'(DEPTH) && !(tx_valid && tx_ready)) |=> $stable(tx_count));

  assert_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count <= CW'(DEPTH)) && (tx_count <= CW'(DEPTH)));

  assert_tx_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
endmodule

bind char_port_regs cpr_checker #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .tx_data(tx_data), .rx_count(rx_level), .tx_count(tx_level)
);

// File: tb/char_port_regs_test.sv
`timescale 1ns/1ps
module char_port_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic [7:0]  rx_data = '0;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic [7:0]  tx_data;
  logic        irq;

  int tests = 0;
  int fails = 0;
  logic [7:0] sb [$];

  always #10 clk = ~clk;

  char_port_regs uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    chk("R2 read strobe", {31'd0, bus_rvalid}, 32'd1);
    d = bus_rdata;
  endtask

  task automatic rx_send(input logic [7:0] d);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  // driver side of the transmit scoreboard
  task automatic tx_write(input logic [7:0] d, input bit accept);
    bus_write(3'd0, {24'hABCDE0, d});
    if (accept) sb.push_back(d);
  endtask

  // monitor side: every completed transmit beat against the expected order
  always @(negedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      if (sb.size() == 0) chk("R4 unexpected tx beat", {24'd0, tx_data}, 32'hFFFF_FFFF);
      else chk("R4 tx order", {24'd0, tx_data}, {24'd0, sb.pop_front()});
    end
  end

  task automatic run_all();
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rx_ready", {31'd0, rx_ready}, 32'd1);
    chk("R1 tx_valid", {31'd0, tx_valid}, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 rvalid", {31'd0, bus_rvalid}, 32'd0);
    bus_read(3'd4, r);
    chk("R8 control after reset", r, 32'h0040_0200);

    rx_send(8'h41); rx_send(8'h42); rx_send(8'h43);
    bus_read(3'd0, r); chk("R2 first pop", r, 32'h0002_8041);
    bus_read(3'd0, r); chk("R2 second pop", r, 32'h0001_8042);
    bus_read(3'd0, r); chk("R2 last pop", r, 32'h0000_8043);
    bus_read(3'd0, r); chk("R3 empty read", r, 32'h0);
    bus_read(3'd4, r); chk("R3 queue still empty", r, 32'h0040_0200);

    for (int i = 0; i < 64; i++) rx_send(8'(i * 3 + 1));
    chk("R6 rx_ready low when full", {31'd0, rx_ready}, 32'd0);
    rx_send(8'h5A);
    bus_read(3'd4, r); chk("R8 control with rx full", r, 32'h0040_0300);
    for (int i = 0; i < 64; i++) begin
      bus_read(3'd0, r);
      chk("R6 full queue drain", r, {16'(63 - i), 8'h80, 8'(i * 3 + 1)});
    end
    bus_read(3'd0, r); chk("R6 extra beat not stored", r, 32'h0);

    bus_write(3'd4, 32'h1);
    chk("R9 irq rx enabled, empty", {31'd0, irq}, 32'd0);
    rx_send(8'h77);
    chk("R9 irq rx pending", {31'd0, irq}, 32'd1);
    bus_read(3'd0, r); chk("R2 pop irq char", r, 32'h0000_8077);
    chk("R9 irq clears after pop", {31'd0, irq}, 32'd0);

    bus_write(3'd4, 32'h2);
    chk("R9 irq tx space", {31'd0, irq}, 32'd1);
    for (int i = 0; i < 33; i++) tx_write(8'(8'h10 + i), 1'b1);
    chk("R9 irq off below half free", {31'd0, irq}, 32'd0);
    bus_read(3'd4, r); chk("R8 free 31", r, 32'h001F_0002);
    for (int i = 33; i < 64; i++) tx_write(8'(8'h10 + i), 1'b1);
    tx_write(8'hEE, 1'b0);
    bus_read(3'd4, r); chk("R5 full write dropped", r, 32'h0000_0002);
    repeat (3) @(negedge clk);
    chk("R7 tx held valid", {31'd0, tx_valid}, 32'd1);
    chk("R7 tx held data", {24'd0, tx_data}, 32'h10);

    @(posedge clk); #5 tx_ready = 1'b1;
    repeat (70) @(negedge clk);
    chk("R4 scoreboard drained", sb.size(), 32'd0);
    chk("R4 tx idle", {31'd0, tx_valid}, 32'd0);
    bus_read(3'd4, r); chk("R10 activity set", r, 32'h0040_0602);
    bus_write(3'd4, 32'h400);
    bus_read(3'd4, r); chk("R10 activity cleared", r, 32'h0040_0200);
    chk("R10 irq off with enables clear", {31'd0, irq}, 32'd0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule